// File: doc/BRIEF.md
# Six-Valued Static Hazard Classifier

This block evaluates one gate of a hazard-analysis pass in six-valued logic. Each six-valued code stands for three successive three-valued samples of a signal: before a change, during it, and after it settles. A signal that changes is unknown in the middle sample. The block accepts two operand codes and an operation select for AND, OR, NAND or NOT. It returns the result code, a flag that marks a static hazard, and an error flag for illegal operand codes.

Internally each operand code is unpacked into its three samples. The selected three-valued operation is applied to each sample position on its own, and the resulting sample triple is packed back into a six-valued code. A glitch shows up as a result whose first and last samples agree while the middle sample differs. A hazard-analysis pass can call the block once per gate, feeding back the result code as an operand of the next gate. Results are registered, so every operation has one cycle of latency.

Top module: `hz6_classifier`

## Requirements
- R1: While rst_n is low, and on the first clock edge after release, res_code is 0 and hazard and err are 0.
- R2: The outputs reflect the inputs present at a rising clock edge from just after that edge; they hold until the next edge.
- R3: Codes are 3 bits: 0 = steady low (samples 0,0,0), 1 = steady high (1,1,1), 2 = rise (0,u,1), 3 = fall (1,u,0), 4 = low with glitch (0,u,0), 5 = high with glitch (1,u,1); res_code never takes a value above 5.
- R4: op_sel 0 selects AND, evaluated separately at each sample position in three-valued logic; for example AND of rise and fall gives code 4.
- R5: op_sel 1 selects OR, evaluated per sample; OR of rise and fall gives code 5.
- R6: op_sel 2 selects NAND, the inversion of the AND result; NAND of rise and fall gives code 5.
- R7: op_sel 3 selects NOT of op_a: 0 and 1 swap, 2 and 3 swap, 4 and 5 swap; op_b has no effect, including when it holds an illegal code.
- R8: hazard is 1 exactly when res_code is 4 or 5.
- R9: Codes 6 and 7 are illegal; when op_a is illegal, or op_b is illegal with op_sel other than 3, err is 1, res_code is 0 and hazard is 0.
- R10: An unknown sample only reaches the output when no operand is controlling: AND with a steady-low operand gives code 0 and OR with a steady-high operand gives code 1, whatever the legal other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 3 | First operand code |
| op_b | input | 3 | Second operand code (unused by NOT) |
| op_sel | input | 2 | Operation: 0 AND, 1 OR, 2 NAND, 3 NOT |
| res_code | output | 3 | Registered result code |
| hazard | output | 1 | Registered static-hazard flag |
| err | output | 1 | Registered illegal-operand flag |

## Verification
On every cycle the assertions hold the agreement between the hazard flag and the glitch codes, the range of the result code, the quiet outputs that accompany an error, the controlling-zero rule for AND and the rise-to-fall inversion of NOT. The full result tables for all four operations, the swap pairs of NOT with illegal op_b values, and the NAND-as-inverted-AND relation are shown only by the bench, which sweeps every operand and operation combination and adds seeded random traffic, comparing each result with a set-based model of the middle sample.

// File: rtl/hz6_pkg.sv
package hz6_pkg;

    localparam int CODE_W  = 3;
    localparam int SEL_W   = 2;
    localparam int SAMPLES = 3;
    localparam int MID     = SAMPLES / 2;
    localparam int LAST    = SAMPLES - 1;

    typedef enum logic [CODE_W-1:0] {
        V_LOW  = 3'd0,
        V_HIGH = 3'd1,
        V_RISE = 3'd2,
        V_FALL = 3'd3,
        V_GLO  = 3'd4,
        V_GHI  = 3'd5
    } hz6_code_e;

    localparam logic [CODE_W-1:0] CODE_MAX = V_GHI;

    typedef enum logic [SEL_W-1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_NAND = 2'd2,
        OP_NOT  = 2'd3
    } hz6_op_e;

    typedef enum logic [1:0] {
        T_ZERO = 2'd0,
        T_ONE  = 2'd1,
        T_UNK  = 2'd2
    } tri_e;

    typedef tri_e [SAMPLES-1:0] seq_t;

    function automatic tri_e tri_and(tri_e x, tri_e y);
        if (x == T_ZERO || y == T_ZERO) return T_ZERO;
        if (x == T_ONE && y == T_ONE)   return T_ONE;
        return T_UNK;
    endfunction

    function automatic tri_e tri_or(tri_e x, tri_e y);
        if (x == T_ONE || y == T_ONE)   return T_ONE;
        if (x == T_ZERO && y == T_ZERO) return T_ZERO;
        return T_UNK;
    endfunction

    function automatic tri_e tri_not(tri_e x);
        if (x == T_ZERO) return T_ONE;
        if (x == T_ONE)  return T_ZERO;
        return T_UNK;
    endfunction

endpackage

// File: rtl/hz6_expand.sv
module hz6_expand
    import hz6_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output seq_t              seq,
    output logic              illegal
);
    always_comb begin
        illegal = 1'b0;
        seq     = {SAMPLES{T_ZERO}};
        case (code)
            V_LOW:  seq = {T_ZERO, T_ZERO, T_ZERO};
            V_HIGH: seq = {T_ONE,  T_ONE,  T_ONE};
            V_RISE: seq = {T_ONE,  T_UNK,  T_ZERO};
            V_FALL: seq = {T_ZERO, T_UNK,  T_ONE};
            V_GLO:  seq = {T_ZERO, T_UNK,  T_ZERO};
            V_GHI:  seq = {T_ONE,  T_UNK,  T_ONE};
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/hz6_tri_op.sv
module hz6_tri_op
    import hz6_pkg::*;
(
    input  seq_t             seq_a,
    input  seq_t             seq_b,
    input  logic [SEL_W-1:0] sel,
    output seq_t             seq_y
);
    for (genvar i = 0; i < SAMPLES; i++) begin : g_pos
        always_comb begin
            case (sel)
                OP_AND:  seq_y[i] = tri_and(seq_a[i], seq_b[i]);
                OP_OR:   seq_y[i] = tri_or(seq_a[i], seq_b[i]);
                OP_NAND: seq_y[i] = tri_not(tri_and(seq_a[i], seq_b[i]));
                default: seq_y[i] = tri_not(seq_a[i]);
            endcase
        end
    end
endmodule

// File: rtl/hz6_compress.sv
module hz6_compress
    import hz6_pkg::*;
(
    input  seq_t              seq,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        if (seq[0] == seq[LAST]) begin
            if (seq[MID] == seq[0])
                code = (seq[0] == T_ONE) ? V_HIGH : V_LOW;
            else
                code = (seq[0] == T_ONE) ? V_GHI : V_GLO;
        end else begin
            code = (seq[0] == T_ZERO) ? V_RISE : V_FALL;
        end
    end
endmodule

// File: rtl/hz6_classifier.sv
module hz6_classifier
    import hz6_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] op_a,
    input  logic [CODE_W-1:0] op_b,
    input  logic [SEL_W-1:0]  op_sel,
    output logic [CODE_W-1:0] res_code,
    output logic              hazard,
    output logic              err
);
    seq_t              seq_a, seq_b, seq_y;
    logic              bad_a, bad_b;
    logic [CODE_W-1:0] code_y;
    logic              err_d, haz_d;

    hz6_expand i_exp_a (.code(op_a), .seq(seq_a), .illegal(bad_a));
    hz6_expand i_exp_b (.code(op_b), .seq(seq_b), .illegal(bad_b));

    hz6_tri_op i_op (.seq_a(seq_a), .seq_b(seq_b), .sel(op_sel), .seq_y(seq_y));

    hz6_compress i_cmp (.seq(seq_y), .code(code_y));

    always_comb begin
        err_d = bad_a || (bad_b && op_sel != OP_NOT);
        haz_d = !err_d && (seq_y[0] == seq_y[LAST]) && (seq_y[MID] != seq_y[0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code <= V_LOW;
            hazard   <= 1'b0;
            err      <= 1'b0;
        end else begin
            res_code <= err_d ? V_LOW : code_y;
            hazard   <= haz_d;
            err      <= err_d;
        end
    end

    // R3: result stays inside the legal code range
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_code <= CODE_MAX);

    // R8: flag and glitch codes agree
    p_haz_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hazard == (res_code == V_GLO || res_code == V_GHI));

    // R9: illegal first operand raises err next cycle
    p_err_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a > CODE_MAX) |=> err);

    // R9: an error keeps the other outputs quiet
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (res_code == V_LOW && !hazard));

    // R10: steady low controls AND
    p_and_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_AND && op_a == V_LOW && op_b <= CODE_MAX)
        |=> (res_code == V_LOW && !err));

    // R7: NOT turns a rise into a fall whatever op_b holds
    p_not_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_NOT && op_a == V_RISE) |=> (res_code == V_FALL && !err));

endmodule

// File: tb/test_hz6_classifier.sv
`timescale 1ns/1ps
module test_hz6_classifier;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_a, op_b;
    logic [1:0] op_sel;
    logic [2:0] res_code;
    logic       hazard, err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    hz6_classifier i_hz6_classifier (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .res_code(res_code), .hazard(hazard), .err(err)
    );

    // first sample, set of possible middle values (bit0: 0 possible, bit1: 1 possible), last sample
    function automatic void unpack(input int c, output bit f, output bit [1:0] m, output bit l);
        case (c)
            0: begin f = 0; m = 2'b01; l = 0; end
            1: begin f = 1; m = 2'b10; l = 1; end
            2: begin f = 0; m = 2'b11; l = 1; end
            3: begin f = 1; m = 2'b11; l = 0; end
            4: begin f = 0; m = 2'b11; l = 0; end
            default: begin f = 1; m = 2'b11; l = 1; end
        endcase
    endfunction

    function automatic bit gate(input int sel, input bit x, input bit y);
        case (sel)
            0: return x & y;
            1: return x | y;
            2: return ~(x & y);
            default: return ~x;
        endcase
    endfunction

    function automatic void model(input int a, input int b, input int sel,
                                  output int code, output bit hz, output bit er);
        bit fa, la, fb, lb, rf, rl;
        bit [1:0] ma, mb, rm;
        er = (a > 5) || (sel != 3 && b > 5);
        code = 0; hz = 0;
        if (!er) begin
            unpack(a, fa, ma, la);
            unpack((sel == 3) ? 0 : b, fb, mb, lb);
            rf = gate(sel, fa, fb);
            rl = gate(sel, la, lb);
            rm = 2'b00;
            for (int xa = 0; xa < 2; xa++)
                for (int xb = 0; xb < 2; xb++)
                    if (ma[xa] && mb[xb]) rm[gate(sel, xa[0], xb[0])] = 1'b1;
            if (rm == 2'b11)
                code = (rf == rl) ? (rf ? 5 : 4) : (rf ? 3 : 2);
            else if (rm[1] == rf && rm[1] == rl)
                code = rf ? 1 : 0;
            else if (rf == rl)
                code = rf ? 5 : 4;
            else
                code = rf ? 3 : 2;
            hz = (code == 4 || code == 5);
        end
    endfunction

    function automatic string op_tag(input int a, input int b, input int sel);
        if (a > 5 || (sel != 3 && b > 5)) return "R9";
        case (sel)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic expect_out(input string tag, input int ec, input bit eh, input bit ee);
        total++;
        if (res_code != ec[2:0] || hazard != eh || err != ee) begin
            bad++;
            $display("FAIL %s: got code=%0d haz=%0d err=%0d expected code=%0d haz=%0d err=%0d",
                     tag, res_code, hazard, err, ec, eh, ee);
        end
    endtask

    // R2: drive on a falling edge, result registered at the next rising edge, sample on the falling edge after it
    task automatic run(input int a, input int b, input int sel, input string tag);
        int ec; bit eh, ee;
        @(negedge clk);
        op_a = a[2:0]; op_b = b[2:0]; op_sel = sel[1:0];
        @(negedge clk);
        model(a, b, sel, ec, eh, ee);
        expect_out(tag, ec, eh, ee);
        total++;
        if (hazard != (res_code == 3'd4 || res_code == 3'd5)) begin
            bad++;
            $display("FAIL R8: got haz=%0d code=%0d expected haz=%0d",
                     hazard, res_code, (res_code == 3'd4 || res_code == 3'd5));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; op_a = 3'd2; op_b = 3'd3; op_sel = 2'd1;
        repeat (3) @(negedge clk);
        expect_out("R1", 0, 0, 0);
        rst_n = 1'b1;

        // directed corners
        run(2, 3, 0, "R4 and rise fall");
        expect_out("R4", 4, 1, 0);
        run(2, 3, 1, "R5 or rise fall");
        expect_out("R5", 5, 1, 0);
        run(2, 3, 2, "R6 nand rise fall");
        expect_out("R6", 5, 1, 0);
        run(4, 7, 3, "R7 not ignores illegal b");
        expect_out("R7", 5, 1, 0);
        run(1, 0, 3, "R3 not of steady high");
        expect_out("R3", 0, 0, 0);
        run(0, 5, 0, "R10 and low control");
        expect_out("R10", 0, 0, 0);
        run(4, 1, 1, "R10 or high control");
        expect_out("R10", 1, 0, 0);
        run(2, 6, 1, "R9 illegal b");
        expect_out("R9", 0, 0, 1);
        run(7, 0, 3, "R9 illegal a under not");
        expect_out("R9", 0, 0, 1);

        // exhaustive sweep
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    run(a, b, s, op_tag(a, b, s));

        // seeded random traffic
        for (int k = 0; k < 400; k++) begin
            int a, b, s;
            a = $urandom_range(0, 7);
            b = $urandom_range(0, 7);
            s = $urandom_range(0, 3);
            run(a, b, s, op_tag(a, b, s));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule